// File: doc/BRIEF.md
# Slice-Style 8-Bit ALU with Latched Status Flags

This block is an accumulator-machine arithmetic/logic unit whose operation is picked the way a cascaded pair of classic 4-bit ALU slices picks it. A four-line function select, a mode bit and an active-low carry input together name the operation. There is no opcode field. The result is combinational from the operand and control inputs. A small flag register records zero, sign and carry for the operation on the inputs at a clock edge where the load enable is high.

The datapath is built as a chain of 4-bit adder slices, and the carry ripples from slice to slice. Only the control combinations that an accumulator instruction set needs are decoded: add, subtract, double, AND, OR, XOR and the two inversions. Every other combination gives a zero result and leaves the flags alone. A controller drives the select lines from its microword, reads `result` back into the accumulator, and raises `flag_load` in the execute step.

Top module: `slice_alu8`

## Requirements
- R1: With `logic_mode`=0 and `fsel`=1001, `result` = (A + B + c) mod 2^W, where c = NOT `carry_in_n`. So `carry_in_n`=1 adds no carry.
- R2: With `logic_mode`=0 and `fsel`=0110, `result` = (A + ~B + c) mod 2^W. With `carry_in_n`=0 this is A minus B in two's complement. The carry out is 1 exactly when no borrow occurred.
- R3: With `logic_mode`=0 and `fsel`=1100, `result` = (A + A + c) mod 2^W. For example, 0x0A gives 0x14 when `carry_in_n`=1.
- R4: With `logic_mode`=1, `fsel`=1011 gives A AND B, 1110 gives A OR B, and 0110 gives A XOR B. `carry_in_n` has no effect.
- R5: With `logic_mode`=1, `fsel`=0000 gives NOT A and 0101 gives NOT B. For example, 0x0A inverts to 0xF5 and 0x08 inverts to 0xF7.
- R6: Any other `logic_mode`/`fsel` combination gives `result` = 0. The flags keep their value even when `flag_load`=1.
- R7: At a rising edge where `flag_load`=1 and the operation is supported, the flags are loaded as follows: `flag_zero` = (result == 0), `flag_sign` = result bit W-1, and `flag_carry` = the carry out of the top bit for R1–R3. `flag_carry` is 0 for R4–R5. For example, 0xFF + 0x01 gives 0x00 with carry=1 and zero=1.
- R8: At an edge where `flag_load`=0, the three flags hold their value.
- R9: At a rising edge where `rst`=1, all three flags are cleared. This happens even when `flag_load`=1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| opa | input | W (8) | Operand A (accumulator side) |
| opb | input | W (8) | Operand B (memory side) |
| fsel | input | 4 | Function select, MSB first |
| logic_mode | input | 1 | 1 = logic only, 0 = arithmetic |
| carry_in_n | input | 1 | Active-low carry into bit 0 |
| flag_load | input | 1 | Load the flags at this edge |
| result | output | W (8) | Combinational result |
| flag_zero | output | 1 | Latched zero flag |
| flag_sign | output | 1 | Latched sign flag |
| flag_carry | output | 1 | Latched carry flag |

## Verification
A flag load and a reset can fall on the same edge. The bench provokes this by raising `rst` while a supported operation that would set carry and zero is present and `flag_load` is high. It then judges that the flags read back cleared on the following cycle. A flag load can also coincide with an unsupported control combination. Every such collision in the full sweep of all 64 control combinations over an operand grid is checked against the previous flag value that the bench model keeps.

// File: rtl/slice_alu8_pkg.sv
package slice_alu8_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_SUB,
    OP_DBL,
    OP_AND,
    OP_OR,
    OP_XOR,
    OP_NOTA,
    OP_NOTB
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
  } alu_flags_t;

endpackage

// File: rtl/slice_alu8_decode.sv
module slice_alu8_decode
  import slice_alu8_pkg::*;
(
  input  logic [3:0] fsel,
  input  logic       logic_mode,
  output alu_op_e    op,
  output logic       op_valid,
  output logic       op_arith
);
  // control codes as {mode, select}
  localparam logic [4:0] C_ADD  = 5'b0_1001;
  localparam logic [4:0] C_SUB  = 5'b0_0110;
  localparam logic [4:0] C_DBL  = 5'b0_1100;
  localparam logic [4:0] C_AND  = 5'b1_1011;
  localparam logic [4:0] C_OR   = 5'b1_1110;
  localparam logic [4:0] C_XOR  = 5'b1_0110;
  localparam logic [4:0] C_NOTA = 5'b1_0000;
  localparam logic [4:0] C_NOTB = 5'b1_0101;

  always_comb begin
    case ({logic_mode, fsel})
      C_ADD:   op = OP_ADD;
      C_SUB:   op = OP_SUB;
      C_DBL:   op = OP_DBL;
      C_AND:   op = OP_AND;
      C_OR:    op = OP_OR;
      C_XOR:   op = OP_XOR;
      C_NOTA:  op = OP_NOTA;
      C_NOTB:  op = OP_NOTB;
      default: op = OP_NONE;
    endcase
  end

  assign op_valid = (op != OP_NONE);
  assign op_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_DBL);

endmodule

// File: rtl/slice_alu8_arith.sv
module slice_alu8_arith
  import slice_alu8_pkg::*;
#(
  parameter int W       = 8,
  parameter int SLICE_W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_e      op,
  input  logic         carry_in_n,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int NSL = W / SLICE_W;

  logic [W-1:0] addend;
  logic [NSL:0] chain;

  always_comb begin
    case (op)
      OP_ADD:  addend = opb;
      OP_SUB:  addend = ~opb;
      OP_DBL:  addend = opa;
      default: addend = '0;
    endcase
  end

  assign chain[0] = ~carry_in_n;

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    logic [SLICE_W:0] part;
    assign part = {1'b0, opa[g*SLICE_W +: SLICE_W]}
                + {1'b0, addend[g*SLICE_W +: SLICE_W]}
                + {{SLICE_W{1'b0}}, chain[g]};
    assign sum[g*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
    assign chain[g+1] = part[SLICE_W];
  end

  assign cout = chain[NSL];

endmodule

// File: rtl/slice_alu8_logic.sv
module slice_alu8_logic
  import slice_alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_e      op,
  output logic [W-1:0] out
);
  always_comb begin
    case (op)
      OP_AND:  out = opa & opb;
      OP_OR:   out = opa | opb;
      OP_XOR:  out = opa ^ opb;
      OP_NOTA: out = ~opa;
      OP_NOTB: out = ~opb;
      default: out = '0;
    endcase
  end

endmodule

// File: rtl/slice_alu8_flagreg.sv
module slice_alu8_flagreg
  import slice_alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         op_valid,
  input  logic         op_arith,
  input  logic [W-1:0] res,
  input  logic         cout,
  output alu_flags_t   flags
);
  alu_flags_t next_f;

  always_comb begin
    next_f.zero  = ~|res;
    next_f.sign  = res[W-1];
    next_f.carry = op_arith & cout;
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags <= '0;
    else if (load && op_valid)
      flags <= next_f;
  end

endmodule

// File: rtl/slice_alu8.sv
module slice_alu8
  import slice_alu8_pkg::*;
#(
  parameter int W       = 8,
  parameter int SLICE_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   fsel,
  input  logic         logic_mode,
  input  logic         carry_in_n,
  input  logic         flag_load,
  output logic [W-1:0] result,
  output logic         flag_zero,
  output logic         flag_sign,
  output logic         flag_carry
);
  alu_op_e      op;
  logic         op_valid;
  logic         op_arith;
  logic [W-1:0] arith_sum;
  logic         arith_cout;
  logic [W-1:0] logic_out;
  alu_flags_t   flags;

  slice_alu8_decode u_dec (
    .fsel       (fsel),
    .logic_mode (logic_mode),
    .op         (op),
    .op_valid   (op_valid),
    .op_arith   (op_arith)
  );

  slice_alu8_arith #(.W(W), .SLICE_W(SLICE_W)) u_arith (
    .opa        (opa),
    .opb        (opb),
    .op         (op),
    .carry_in_n (carry_in_n),
    .sum        (arith_sum),
    .cout       (arith_cout)
  );

  slice_alu8_logic #(.W(W)) u_logic (
    .opa (opa),
    .opb (opb),
    .op  (op),
    .out (logic_out)
  );

  always_comb begin
    if (!op_valid)     result = '0;
    else if (op_arith) result = arith_sum;
    else               result = logic_out;
  end

  slice_alu8_flagreg #(.W(W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .load     (flag_load),
    .op_valid (op_valid),
    .op_arith (op_arith),
    .res      (result),
    .cout     (arith_cout),
    .flags    (flags)
  );

  assign flag_zero  = flags.zero;
  assign flag_sign  = flags.sign;
  assign flag_carry = flags.carry;

endmodule

// File: rtl/slice_alu8_chk.sv
module slice_alu8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   fsel,
  input logic         logic_mode,
  input logic         flag_load,
  input logic         op_valid,
  input logic [W-1:0] result,
  input logic         flag_zero,
  input logic         flag_sign,
  input logic         flag_carry
);
  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  // R9
  flags_clear_chk: assert property (@(posedge clk) disable iff (!past_valid)
    $past(rst) |-> !flag_zero && !flag_sign && !flag_carry);

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_valid)
    !flag_load |=> $stable({flag_zero, flag_sign, flag_carry}));

  // R6
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> result == '0);

  // R6
  bad_op_flags_chk: assert property (@(posedge clk) disable iff (rst || !past_valid)
    !op_valid |=> $stable({flag_zero, flag_sign, flag_carry}));

  // R7
  flag_capture_chk: assert property (@(posedge clk) disable iff (rst || !past_valid)
    flag_load && op_valid |=>
      (flag_zero == ($past(result) == '0)) && (flag_sign == $past(result[W-1])));

  // R7
  logic_carry_chk: assert property (@(posedge clk) disable iff (rst || !past_valid)
    flag_load && op_valid && logic_mode |=> !flag_carry);

  // R4
  and_op_chk: assert property (@(posedge clk) disable iff (rst)
    logic_mode && fsel == 4'b1011 |-> result == (opa & opb));

endmodule

bind slice_alu8 slice_alu8_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opa        (opa),
  .opb        (opb),
  .fsel       (fsel),
  .logic_mode (logic_mode),
  .flag_load  (flag_load),
  .op_valid   (op_valid),
  .result     (result),
  .flag_zero  (flag_zero),
  .flag_sign  (flag_sign),
  .flag_carry (flag_carry)
);

// File: tb/tb_slice_alu8.sv
module tb_slice_alu8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic [3:0] fsel = '0;
  logic       logic_mode = 1'b0;
  logic       carry_in_n = 1'b1;
  logic       flag_load = 1'b0;
  logic [7:0] result;
  logic       flag_zero, flag_sign, flag_carry;

  int checks = 0;
  int errors = 0;
  logic [2:0] mflags = '0; // {zero, sign, carry}

  always #4 clk = ~clk;

  slice_alu8 dut (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .fsel(fsel),
    .logic_mode(logic_mode), .carry_in_n(carry_in_n), .flag_load(flag_load),
    .result(result), .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_carry(flag_carry)
  );

  // returns {valid, carry, result}
  function automatic logic [9:0] model(input int a, input int b, input int s,
                                       input int m, input int cn);
    int c = (cn == 0) ? 1 : 0;
    int t = 0;
    logic v = 1'b1;
    logic cy = 1'b0;
    if (m == 0) begin
      case (s)
        9:  t = a + b + c;
        6:  t = a + (255 - b) + c;
        12: t = a + a + c;
        default: v = 1'b0;
      endcase
      cy = v && (t > 255);
    end else begin
      case (s)
        11: t = a & b;
        14: t = a | b;
        6:  t = a ^ b;
        0:  t = 255 - a;
        5:  t = 255 - b;
        default: v = 1'b0;
      endcase
    end
    if (!v) t = 0;
    return {v, cy, 8'(t & 255)};
  endfunction

  function automatic string tag_of(input int s, input int m);
    if (m == 0 && s == 9)  return "R1";
    if (m == 0 && s == 6)  return "R2";
    if (m == 0 && s == 12) return "R3";
    if (m == 1 && (s == 11 || s == 14 || s == 6)) return "R4";
    if (m == 1 && (s == 0 || s == 5)) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply at negedge, check result, then step one edge and check flags
  task automatic apply(input int a, input int b, input int s, input int m,
                       input int cn, input logic ld, input logic rs);
    logic [9:0] e;
    @(negedge clk);
    opa = 8'(a); opb = 8'(b); fsel = 4'(s); logic_mode = 1'(m);
    carry_in_n = 1'(cn); flag_load = ld; rst = rs;
    e = model(a, b, s, m, cn);
    #1 check(tag_of(s, m), int'(result), int'(e[7:0]));
    if (rs) mflags = '0;
    else if (ld && e[9]) mflags = {e[7:0] == 8'h00, e[7], e[8]};
    @(posedge clk);
    #1 check(rs ? "R9" : (!ld ? "R8" : (e[9] ? "R7" : "R6")),
             int'({flag_zero, flag_sign, flag_carry}), int'(mflags));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R9", int'({flag_zero, flag_sign, flag_carry}), 0);
    // directed corners
    apply(8'hFF, 8'h01, 9, 0, 1, 1'b1, 1'b0); // R1 wrap: 00, c=1 z=1
    check("R7", int'({flag_zero, flag_sign, flag_carry}), 3'b101);
    apply(8'h0A, 8'h00, 12, 0, 1, 1'b1, 1'b0); // R3 doubling 0x14
    check("R3", int'(result), 8'h14);
    apply(8'h0A, 8'h33, 0, 1, 0, 1'b1, 1'b0); // R5 not A
    check("R5", int'(result), 8'hF5);
    apply(8'h33, 8'h08, 5, 1, 1, 1'b1, 1'b0); // R5 not B
    check("R5", int'(result), 8'hF7);
    apply(8'h05, 8'h07, 6, 0, 0, 1'b1, 1'b0); // R2 borrow: FE, carry 0
    check("R2", int'(flag_carry), 0);
    apply(8'h07, 8'h05, 6, 0, 0, 1'b1, 1'b0); // R2 no borrow: carry 1
    check("R2", int'(flag_carry), 1);
    // reset colliding with a load that would set carry and zero
    apply(8'hFF, 8'h01, 9, 0, 1, 1'b1, 1'b0);
    apply(8'hFF, 8'h01, 9, 0, 1, 1'b1, 1'b1);
    check("R9", int'({flag_zero, flag_sign, flag_carry}), 0);
    // sweep all control combinations over an operand grid
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++)
        for (int cn = 0; cn < 2; cn++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
              apply(i * 17, (j * 17) ^ 8'h5A, s, m, cn,
                    1'(((i + j + s) % 3) != 0), 1'(((i * 16 + j) % 97) == 41));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule